// File: doc/BRIEF.md
# Priority-Gated Debug Break Controller

This block decides when a processor core is stopped for debugging. Five request sources feed it: a software-break event, an instruction-address breakpoint hit, a trigger-unit hit (address, data or task-ID match), an external break pin, and a register write that forces a break. The first two are always accepted. The last three are gated by priority. A gated request may stop the core only while a programmable break level is strictly above the core's current priority level. Until then the request is held pending. It is released as soon as either level changes so that the condition holds.

When a break is taken, the block raises a registered halt output. In the same edge it loads a status register with the cause of that break and with a bit for every other source that was pending at that moment. The status therefore describes the break actually taken and never a leftover request. The halt stays up until a resume pulse. The resume pulse also discards every pending request. A small write port sets the break level, clears the status and forces a break.

Top module: `brk_halt_ctrl`

## Requirements
- R1: After a synchronous reset, `halt` is 0, `brk_status` is 0 and the break level is 15.
- R2: A gated source (trigger hit, external pin or forced write) raises `halt` one clock after it is sampled, but only when the break level is strictly greater than `core_lvl`.
- R3: While `core_lvl` is greater than or equal to the break level, a gated request stays pending. It raises `halt` on the first edge at which the strict-greater condition holds, whether `core_lvl` was lowered or the break level was raised.
- R4: `sw_brk` and `hw_bp_hit` raise `halt` one clock later regardless of the two levels, even while a gated request is pending.
- R5: When `halt` rises, `brk_status[2:0]` holds the cause of that break: 1 software break, 2 address breakpoint, 3 trigger, 4 external pin, 5 forced write. It never holds the cause of an earlier request that is still pending.
- R6: When several sources are eligible on the same edge, the winner follows this order: software break first, then address breakpoint, trigger, external pin, and forced write last. `brk_status[7:3]` sets bit 3+k for each other pending or requesting source k, in the same order (bit 3 software break through bit 7 forced write).
- R7: `halt` stays high until `resume`, and requests arriving while halted are ignored. `resume` clears `halt` and all pending requests, and a request sampled with `resume` is dropped.
- R8: A write to address 1 clears `brk_status` to 0. If a break is taken on the same edge, the new cause is stored instead.
- R9: A write to address 0 loads the break level from `wr_data[3:0]`. The new level gates requests from the next edge on. A write to address 2 is a forced-break request.
- R10: With a break level of 15 and `core_lvl` at 14 or below, every gated request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_lvl | input | 4 | Current core priority level |
| sw_brk | input | 1 | Software-break event (ungated) |
| hw_bp_hit | input | 1 | Instruction-address breakpoint hit (ungated) |
| trig_hit | input | 1 | Address/data/task-ID trigger hit (gated) |
| ext_brk_pin | input | 1 | External break pin, synchronous (gated) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 level, 1 status clear, 2 force break |
| wr_data | input | 8 | Write data |
| resume | input | 1 | Resume pulse, releases halt and drops pending requests |
| halt | output | 1 | Core halt request, registered |
| brk_status | output | 8 | Cause code [2:0], other pending sources [7:3] |

## Verification
The embedded properties watch several behaviours on every cycle. They check that halt holds until resume and drops right after it, and that an ungated request always stops a running core. They check that a gated cause never appears without the level condition on the deciding edge, that a rising halt always carries a non-zero cause, and that the status is frozen while halted unless a clear is written. Other behaviours only appear in the bench's scenarios. These are precedence among simultaneous sources, release of a held request by either level register, the absence of a stale cause after mixed pending requests, the clear-versus-break collision and the dropping of requests at resume. The bench's cycle model compares both outputs on every clock throughout.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int SRC_N  = 5;
  localparam int CODE_W = 3;
  localparam int STAT_W = SRC_N + CODE_W;
  localparam int AW     = 2;

  // source index = precedence (0 wins)
  localparam int SRC_SW    = 0;
  localparam int SRC_HWBP  = 1;
  localparam int SRC_TRIG  = 2;
  localparam int SRC_PIN   = 3;
  localparam int SRC_FORCE = 4;

  localparam logic [SRC_N-1:0] GATED_SRC = 5'b11100;

  localparam logic [AW-1:0] ADDR_LVL   = 2'd0;
  localparam logic [AW-1:0] ADDR_CLR   = 2'd1;
  localparam logic [AW-1:0] ADDR_FORCE = 2'd2;

  typedef struct packed {
    logic [SRC_N-1:0]  others;
    logic [CODE_W-1:0] code;
  } brk_stat_t;
endpackage

// File: rtl/brk_cfg_regs.sv
module brk_cfg_regs
  import brk_pkg::*;
#(
  parameter int LVL_W   = 4,
  parameter int DW      = 8,
  parameter int RST_LVL = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [LVL_W-1:0] brk_lvl,
  output logic             clr_req,
  output logic             force_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      brk_lvl <= LVL_W'(RST_LVL);
    end else if (wr_en && wr_addr == ADDR_LVL) begin
      brk_lvl <= wr_data[LVL_W-1:0];
    end
  end

  assign clr_req   = wr_en && (wr_addr == ADDR_CLR);
  assign force_req = wr_en && (wr_addr == ADDR_FORCE);
endmodule

// File: rtl/brk_pend_track.sv
module brk_pend_track #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         resume,
  input  logic         halted,
  input  logic [N-1:0] grant,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] active
);
  assign active = halted ? '0 : (pend_q | req);

  always_ff @(posedge clk) begin
    if (rst || resume) begin
      pend_q <= '0;
    end else if (!halted) begin
      pend_q <= active & ~grant;
    end
  end
endmodule

// File: rtl/brk_arbiter.sv
module brk_arbiter #(
  parameter int N = 5
) (
  input  logic [N-1:0] elig,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pri
    assign grant[i]  = elig[i] & ~seen[i];
    assign seen[i+1] = seen[i] | elig[i];
  end

  assign any = seen[N];
endmodule

// File: rtl/brk_halt_ctrl.sv
module brk_halt_ctrl
  import brk_pkg::*;
#(
  parameter int LVL_W   = 4,
  parameter int DW      = 8,
  parameter int RST_LVL = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LVL_W-1:0]  core_lvl,
  input  logic              sw_brk,
  input  logic              hw_bp_hit,
  input  logic              trig_hit,
  input  logic              ext_brk_pin,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              resume,
  output logic              halt,
  output logic [STAT_W-1:0] brk_status
);
  logic [LVL_W-1:0] brk_lvl;
  logic             clr_req, force_req;
  logic [SRC_N-1:0] req, pend_q, active, elig, grant;
  logic             take, gate_open;
  logic [CODE_W-1:0] code;
  brk_stat_t        stat_q;

  brk_cfg_regs #(.LVL_W(LVL_W), .DW(DW), .RST_LVL(RST_LVL)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .brk_lvl(brk_lvl), .clr_req(clr_req), .force_req(force_req)
  );

  always_comb begin
    req            = '0;
    req[SRC_SW]    = sw_brk;
    req[SRC_HWBP]  = hw_bp_hit;
    req[SRC_TRIG]  = trig_hit;
    req[SRC_PIN]   = ext_brk_pin;
    req[SRC_FORCE] = force_req;
  end

  brk_pend_track #(.N(SRC_N)) u_pend (
    .clk(clk), .rst(rst), .req(req), .resume(resume), .halted(halt),
    .grant(grant), .pend_q(pend_q), .active(active)
  );

  assign gate_open = brk_lvl > core_lvl;
  assign elig = resume ? '0 : (active & (gate_open ? {SRC_N{1'b1}} : ~GATED_SRC));

  brk_arbiter #(.N(SRC_N)) u_arb (.elig(elig), .grant(grant), .any(take));

  always_comb begin
    code = '0;
    for (int i = 0; i < SRC_N; i++) begin
      if (grant[i]) code = CODE_W'(i + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halt   <= 1'b0;
      stat_q <= '0;
    end else begin
      if (resume)    halt <= 1'b0;
      else if (take) halt <= 1'b1;

      if (take) begin
        stat_q.code   <= code;
        stat_q.others <= active & ~grant;
      end else if (clr_req) begin
        stat_q <= '0;
      end
    end
  end

  assign brk_status = stat_q;

  // R7: halt holds until resume
  assert_halt_hold_R7: assert property (@(posedge clk) disable iff (rst)
    halt && !resume |=> halt);
  // R7: resume releases halt
  assert_resume_release_R7: assert property (@(posedge clk) disable iff (rst)
    resume |=> !halt);
  // R4: ungated request always stops a running core
  assert_ungated_take_R4: assert property (@(posedge clk) disable iff (rst)
    !halt && !resume && (sw_brk || hw_bp_hit) |=> halt);
  // R5: a rising halt always carries a cause
  assert_cause_present_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(halt) |-> brk_status[CODE_W-1:0] != '0);
  // R2: gated cause only when break level exceeded core level on the deciding edge
  assert_gated_needs_level_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(halt) && brk_status[CODE_W-1:0] > CODE_W'(2) |-> $past(brk_lvl > core_lvl));
  // R7: status frozen while halted unless cleared
  assert_status_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    halt && !resume && !clr_req |=> $stable(brk_status));
  // R8: clear while no break can be taken empties the status
  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    clr_req && (halt || resume) |=> brk_status == '0);
  // R6: at most one winner
  assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
endmodule

// File: tb/tb_brk_halt_ctrl.sv
`timescale 1ns/1ps
module tb_brk_halt_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] core_lvl;
  logic       sw_brk, hw_bp_hit, trig_hit, ext_brk_pin, wr_en, resume;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       halt;
  logic [7:0] brk_status;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  brk_halt_ctrl dut (
    .clk(clk), .rst(rst), .core_lvl(core_lvl), .sw_brk(sw_brk), .hw_bp_hit(hw_bp_hit),
    .trig_hit(trig_hit), .ext_brk_pin(ext_brk_pin), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .resume(resume), .halt(halt), .brk_status(brk_status)
  );

  // behavioural reference model
  int m_halt, m_stat, m_pend, m_lvl;
  bit m_valid = 0;

  always @(posedge clk) begin
    int rq, act, win, gate;
    if (rst) begin
      m_halt = 0; m_stat = 0; m_pend = 0; m_lvl = 15; m_valid = 1;
    end else begin
      rq = 0;
      if (sw_brk)      rq |= 1;
      if (hw_bp_hit)   rq |= 2;
      if (trig_hit)    rq |= 4;
      if (ext_brk_pin) rq |= 8;
      if (wr_en && wr_addr == 2) rq |= 16;
      win = -1;
      if (resume) begin
        m_halt = 0; m_pend = 0;
      end else if (m_halt == 0) begin
        act  = m_pend | rq;
        gate = (m_lvl > int'(core_lvl)) ? 31 : 3;
        for (int i = 4; i >= 0; i--) if (((act & gate) >> i) & 1) win = i;
        if (win >= 0) begin
          m_halt = 1;
          m_stat = (win + 1) | ((act & ~(1 << win)) << 3);
          m_pend = act & ~(1 << win);
        end else m_pend = act;
      end
      if (win < 0 && wr_en && wr_addr == 1) m_stat = 0;
      if (wr_en && wr_addr == 0) m_lvl = int'(wr_data[3:0]);
    end
  end

  always @(negedge clk) begin
    if (m_valid && !rst && !done) begin
      n_chk++;
      if (int'(halt) != m_halt || int'(brk_status) != m_stat) begin
        n_fail++;
        $display("FAIL R5/R7 per-cycle model: halt=%0d status=%02h expected halt=%0d status=%02h",
                 halt, brk_status, m_halt, m_stat);
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 0;
  endtask

  task automatic do_resume();
    resume = 1; cyc(); resume = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; core_lvl = 0; sw_brk = 0; hw_bp_hit = 0; trig_hit = 0; ext_brk_pin = 0;
    wr_en = 0; wr_addr = 0; wr_data = 0; resume = 0;
    cyc(3);
    rst = 0;
    cyc();
    chk("R1 halt after reset", halt, 0);
    chk("R1 status after reset", brk_status, 0);

    // R10 / R1: reset level 15, core 14 lets trigger through
    core_lvl = 14; trig_hit = 1; cyc(); trig_hit = 0;
    chk("R10 trigger at level 15 core 14", halt, 1);
    chk("R2 trigger cause", brk_status, 8'h03);
    do_resume();
    chk("R7 resume clears halt", halt, 0);

    // R3: held while core >= level, released by lowering core
    core_lvl = 15; ext_brk_pin = 1; cyc(); ext_brk_pin = 0;
    cyc(3);
    chk("R3 pin held while core>=level", halt, 0);
    core_lvl = 3; cyc();
    chk("R3 released by core level", halt, 1);
    chk("R3 pin cause", brk_status, 8'h04);
    do_resume();

    // R9 level write, R4 software break over pending trigger, R6 others bit
    wr(2'd0, 8'h05);
    core_lvl = 5; trig_hit = 1; cyc(); trig_hit = 0; cyc();
    chk("R9 level 5 blocks core 5", halt, 0);
    sw_brk = 1; cyc(); sw_brk = 0;
    chk("R4 software break with pending trigger", halt, 1);
    chk("R6 sw cause plus trigger pending bit", brk_status, 8'h21);
    do_resume();
    wr(2'd0, 8'h09); cyc(2);
    chk("R7 pending dropped by resume", halt, 0);

    // R3: released by raising the break level
    wr(2'd0, 8'h05);
    ext_brk_pin = 1; cyc(); ext_brk_pin = 0; cyc();
    chk("R3 pin held at equal levels", halt, 0);
    wr(2'd0, 8'h06);
    chk("R9 new level not yet used on write edge", halt, 0);
    cyc();
    chk("R3 released by break level", halt, 1);
    chk("R3 pin cause after level raise", brk_status, 8'h04);
    do_resume();

    // R5: stale forced request must not be reported
    core_lvl = 8;
    wr(2'd2, 8'h00); cyc();
    chk("R2 forced write held", halt, 0);
    hw_bp_hit = 1; cyc(); hw_bp_hit = 0;
    chk("R5 breakpoint cause not stale force", brk_status, 8'h82);
    do_resume();
    wr(2'd2, 8'h00); cyc();
    chk("R9 force held", halt, 0);
    core_lvl = 2; cyc();
    chk("R5 forced cause", brk_status, 8'h05);
    do_resume();

    // R6: all sources same cycle
    core_lvl = 0;
    sw_brk = 1; hw_bp_hit = 1; trig_hit = 1; ext_brk_pin = 1;
    wr_en = 1; wr_addr = 2; wr_data = 0;
    cyc();
    sw_brk = 0; hw_bp_hit = 0; trig_hit = 0; ext_brk_pin = 0; wr_en = 0;
    chk("R6 precedence and others", brk_status, 8'hF1);

    // R7: ignored while halted
    hw_bp_hit = 1; trig_hit = 1; cyc(); hw_bp_hit = 0; trig_hit = 0;
    cyc(3);
    chk("R7 halt held", halt, 1);
    chk("R7 status unchanged while halted", brk_status, 8'hF1);

    // R8: clear while halted
    wr(2'd1, 8'h00);
    chk("R8 clear while halted", brk_status, 0);
    chk("R8 clear keeps halt", halt, 1);
    do_resume();

    // R8: clear collides with a new break
    trig_hit = 1; wr_en = 1; wr_addr = 1; cyc(); trig_hit = 0; wr_en = 0;
    chk("R8 break wins over clear", brk_status, 8'h03);
    do_resume();

    // R7: request with resume is dropped
    sw_brk = 1; resume = 1; cyc(); sw_brk = 0; resume = 0;
    chk("R7 resume beats request", halt, 0);
    cyc();
    chk("R7 dropped request stays dropped", halt, 0);
    wr(2'd1, 8'h00);
    chk("R8 clear after resume", brk_status, 0);

    cyc(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule